// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block sits behind an external dual-modulus prescaler in a frequency synthesizer loop. The prescaler divides the oscillator by either P or P+1, selected by a modulus-control line. This block counts the prescaler's output pulses with two counters. A swallow counter holds the prescaler in its P+1 mode for the first A pulses of each cycle. A main counter closes the cycle after B pulses. One output pulse per cycle therefore stands for P×B + A oscillator periods, and that pulse feeds the phase detector.

The prescaler output is the block's only clock. The A and B values arrive from a configuration latch, and the block reads them only at a cycle boundary. A narrow-swallow input limits A to its low four bits for the lower-frequency channel. A synchronous clear returns both counters to their empty start state. A hold input freezes the counters for powerdown without losing their contents.

Top module: `swallow_div`

## Requirements
- R1: Each output cycle spans exactly P×B + A oscillator periods, for either prescaler modulus.
- R2: The modulus line `mod_hi` (1 = divide by P+1, 0 = divide by P) is high for exactly the first A prescaler periods of a cycle and low for the remaining B−A. With A = 0 it never rises.
- R3: With A equal to B the whole cycle runs in P+1 mode, giving (P+1)×B periods.
- R4: `div_pulse` rises on the B-th prescaler edge of a cycle and is high for exactly one prescaler period. This holds over the full main-count range, 3 up to 2047.
- R5: With `narrow` = 1 only `a_val[3:0]` is used, and `a_val[6:4]` has no effect on the ratio or on `mod_hi`.
- R6: A change of `a_val`/`b_val` in mid-cycle leaves the running cycle at its old ratio. The new ratio starts with the next cycle.
- R7: `cnt_clr` sampled high empties both counters and drives `mod_hi` and `div_pulse` low on the next edge. The following edge loads A and B, so the first pulse comes P×(B+1) + A periods after the clearing edge.
- R8: While `hold` is sampled high the counters keep their values and no pulse is produced. Counting resumes where it stopped, so a cycle with H held edges and A = 0 lasts P×(B+H) periods.
- R9: During reset, and after it before the first load, `mod_hi` and `div_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Prescaler output, the counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_clr | input | 1 | Synchronous counter clear |
| hold | input | 1 | Powerdown freeze of both counters |
| narrow | input | 1 | Use only the low four bits of the swallow value |
| a_val | input | 7 | Swallow count A |
| b_val | input | 11 | Main count B |
| mod_hi | output | 1 | Modulus control to the prescaler, 1 selects P+1 |
| div_pulse | output | 1 | Divided output, one pulse per cycle |

## Verification
The assertions assume that every loaded main count is at least 3. They also assume that the effective swallow count never exceeds it, and that `cnt_clr` and `hold` are synchronous to the prescaler output. Outside these limits the single-period pulse and the swallow-below-main ordering need not hold. The stimulus changes control inputs only on the falling edge of the prescaler clock and programs only legal pairs, including A = 0, A = B, B = 3 and B = 2047. Its prescaler model latches the modulus two oscillator periods after each of its output edges. The counters have settled by then.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int A_W      = 7,
  parameter int B_W      = 11,
  parameter int NARROW_W = 4
) (
  input  logic           pclk,
  input  logic           rst_n,
  input  logic           cnt_clr,
  input  logic           hold,
  input  logic           narrow,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           mod_hi,
  output logic           div_pulse
);

  localparam logic [A_W-1:0] NMASK = A_W'((1 << NARROW_W) - 1);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_eff;
  logic           at_end;

  assign a_eff  = narrow ? (a_val & NMASK) : a_val;
  assign at_end = (b_cnt <= B_ONE);
  assign mod_hi = (a_cnt != '0);

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt     <= '0;
      b_cnt     <= '0;
      div_pulse <= 1'b0;
    end else if (cnt_clr) begin
      a_cnt     <= '0;
      b_cnt     <= '0;
      div_pulse <= 1'b0;
    end else if (hold) begin
      div_pulse <= 1'b0;
    end else if (at_end) begin
      a_cnt     <= a_eff;
      b_cnt     <= b_val;
      div_pulse <= (b_cnt == B_ONE);
    end else begin
      b_cnt     <= b_cnt - B_ONE;
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      div_pulse <= 1'b0;
    end
  end

endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int A_W = 7,
  parameter int B_W = 11
) (
  input logic           pclk,
  input logic           rst_n,
  input logic           cnt_clr,
  input logic           hold,
  input logic           mod_hi,
  input logic           div_pulse,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);

  p_pulse_at_terminal_r4: assert property (@(posedge pclk) disable iff (!rst_n)
    div_pulse |-> ($past(b_cnt) == B_W'(1)) && !$past(cnt_clr) && !$past(hold));

  p_pulse_one_period_r4: assert property (@(posedge pclk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_mod_rises_on_load_r2: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(mod_hi) |-> ($past(b_cnt) <= B_W'(1)));

  p_swallow_within_main_r3: assert property (@(posedge pclk) disable iff (!rst_n)
    B_W'(a_cnt) <= b_cnt);

  p_clear_to_start_r7: assert property (@(posedge pclk) disable iff (!rst_n)
    cnt_clr |=> (a_cnt == '0) && (b_cnt == '0) && !mod_hi && !div_pulse);

  p_hold_freezes_r8: assert property (@(posedge pclk) disable iff (!rst_n)
    (hold && !cnt_clr) |=> $stable(a_cnt) && $stable(b_cnt) && !div_pulse);

endmodule

bind swallow_div swallow_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .pclk(pclk), .rst_n(rst_n), .cnt_clr(cnt_clr), .hold(hold),
  .mod_hi(mod_hi), .div_pulse(div_pulse), .a_cnt(a_cnt), .b_cnt(b_cnt)
);

// File: tb/sim_swallow_div.sv
`timescale 1ns/1ps
module sim_swallow_div;

  typedef struct {
    int    vco;
    int    hi;
    string tag;
  } exp_t;

  logic       vco = 1'b0;
  logic       pclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_clr = 1'b0;
  logic       hold = 1'b0;
  logic       narrow = 1'b0;
  logic [6:0] a_val = '0;
  logic [10:0] b_val = 11'd3;
  logic       mod_hi;
  logic       div_pulse;

  int   pval = 64;
  int   plen = 64;
  int   pc = 0;
  int   vcount = 0;
  int   hi_tot = 0;
  int   checks = 0;
  int   errors = 0;
  int   nrise = 0;
  int   remark_seq = 0;
  exp_t q[$];

  always #2.5 vco = ~vco;

  swallow_div u0 (
    .pclk(pclk), .rst_n(rst_n), .cnt_clr(cnt_clr), .hold(hold), .narrow(narrow),
    .a_val(a_val), .b_val(b_val), .mod_hi(mod_hi), .div_pulse(div_pulse)
  );

  // prescaler model: divides by pval or pval+1, modulus latched early in each period
  always @(posedge vco) begin
    vcount <= vcount + 1;
    if (!rst_n) begin
      pc   <= 0;
      pclk <= 1'b0;
      plen <= pval;
    end else begin
      if (pc >= plen - 1) begin
        pc   <= 0;
        pclk <= 1'b1;
      end else begin
        pc <= pc + 1;
      end
      if (pc == 2) pclk <= 1'b0;
      if (pc == 1) begin
        plen <= mod_hi ? pval + 1 : pval;
        if (mod_hi) hi_tot <= hi_tot + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  int  mark = 0;
  int  hi_base = 0;
  int  last_pedge = 0;
  int  npe = 0;
  int  npe_rise = 0;
  int  seen_seq = 0;
  bit  dp_q = 1'b0;
  bit  pk_q = 1'b0;

  always @(negedge vco) begin
    if (pclk && !pk_q) begin
      last_pedge = vcount;
      npe++;
    end
    pk_q = pclk;
    if (remark_seq != seen_seq) begin
      seen_seq = remark_seq;
      mark     = last_pedge;
      hi_base  = hi_tot;
    end
    if (div_pulse && !dp_q) begin
      nrise++;
      npe_rise = npe;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk((vcount - mark) == e.vco, {e.tag, " ratio"}, vcount - mark, e.vco);
        chk((hi_tot - hi_base) == e.hi, {e.tag, " P+1 periods"}, hi_tot - hi_base, e.hi);
      end
      mark    = vcount;
      hi_base = hi_tot;
    end
    if (!div_pulse && dp_q)
      chk((npe - npe_rise) == 1, "R4 pulse width", npe - npe_rise, 1);
    dp_q = div_pulse;
  end

  task automatic wait_rise();
    int n;
    n = nrise;
    while (nrise == n) @(negedge vco);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge vco);
  endtask

  task automatic cfg(input int p, input bit nar, input int a, input int b);
    wait_idle();
    pval   = p;
    narrow = nar;
    a_val  = 7'(a);
    b_val  = 11'(b);
    wait_rise();
  endtask

  task automatic push(input int n, input string tag);
    int ae;
    ae = narrow ? int'(a_val[3:0]) : int'(a_val);
    for (int i = 0; i < n; i++) q.push_back('{pval * int'(b_val) + ae, ae, tag});
    wait_idle();
  endtask

  initial begin
    repeat (20) @(posedge vco);
    @(negedge vco);
    chk(!mod_hi, "R9 mod_hi in reset", int'(mod_hi), 0);
    chk(!div_pulse, "R9 div_pulse in reset", int'(div_pulse), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge vco);
    chk(!mod_hi && !div_pulse, "R9 outputs before first load", int'(mod_hi) + int'(div_pulse), 0);

    cfg(64, 0, 5, 10);   push(3, "R1 P=64 A=5 B=10");
    cfg(128, 0, 0, 4);   push(2, "R2 P=128 A=0");
    cfg(64, 0, 7, 7);    push(2, "R3 A=B=7");
    cfg(8, 1, 'h35, 12); push(2, "R5 narrow a=0x35");
    cfg(16, 1, 15, 15);  push(2, "R5 narrow A=B=15 P=16");
    cfg(8, 0, 0, 3);     push(2, "R4 B=3 minimum");
    cfg(8, 0, 127, 2047); push(1, "R4 B=2047 A=127");

    // R6: mid-cycle change
    cfg(64, 0, 3, 9);
    repeat (100) @(negedge vco);
    a_val = 7'd10;
    b_val = 11'd12;
    q.push_back('{64 * 9 + 3, 3, "R6 running cycle keeps old"});
    q.push_back('{64 * 12 + 10, 10, "R6 next cycle takes new"});
    wait_idle();

    // R7: counter clear in mid-cycle
    cfg(16, 0, 4, 6);
    repeat (3) @(posedge pclk);
    @(negedge pclk);
    cnt_clr = 1'b1;
    @(posedge pclk);
    @(negedge pclk);
    cnt_clr = 1'b0;
    chk(!mod_hi && !div_pulse, "R7 outputs low after clear", int'(mod_hi) + int'(div_pulse), 0);
    remark_seq++;
    q.push_back('{16 * 7 + 4, 4, "R7 first cycle after clear"});
    wait_idle();

    // R8: hold for four prescaler edges
    cfg(8, 0, 0, 5);
    q.push_back('{8 * (5 + 4), 0, "R8 cycle stretched by hold"});
    @(negedge pclk);
    hold = 1'b1;
    repeat (4) @(posedge pclk);
    @(negedge pclk);
    chk(!div_pulse, "R8 no pulse while held", int'(div_pulse), 0);
    hold = 1'b0;
    wait_idle();
    push(1, "R8 normal cycle after hold");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge vco);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule